// File: doc/BRIEF.md
# Cascadable 4-Bit Magnitude Comparator

This block compares two unsigned 4-bit operands and reports the result on three flags: greater, equal and less. It is purely combinational. It has no clock, no reset and no stored state.

Three cascade inputs carry the verdict of a less significant stage into the block. When the local operands differ, the local compare decides the result and the cascade inputs have no effect. When the local operands are equal, the block forwards the cascade inputs. This lets stages be chained into wider comparators. The most significant stage gives the final answer.

The least significant stage of a chain must be tied to cascade-equal = 1 and cascade-greater = cascade-less = 0. The operand width is a parameter whose default is 4.

Top module: `magcmp_stage`

## Requirements
- R1: When a_i > b_i (unsigned), the outputs are gt_o=1, eq_o=0, lt_o=0.
- R2: When a_i < b_i (unsigned), the outputs are gt_o=0, eq_o=0, lt_o=1.
- R3: When a_i == b_i, {gt_o, eq_o, lt_o} equals {casc_gt_i, casc_eq_i, casc_lt_i} bit for bit. This holds for all eight cascade patterns, including illegal ones such as 000 and 111.
- R4: When exactly one cascade input is high, exactly one output is high.
- R5: The compare is unsigned and decided at the most significant differing bit. For example, 4'b1000 is greater than 4'b0111, and 4'b0001 is less than 4'b1110.
- R6: When a_i != b_i, none of the eight cascade patterns changes any output.
- R7: Two stages chained form a correct 8-bit unsigned comparator. The low stage is fed cascade 1 on equal and 0 on greater and less. The high stage takes the low stage's three outputs as its cascade inputs. The chain is correct for every pair of 8-bit values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Operand A, unsigned |
| b_i | input | 4 | Operand B, unsigned |
| casc_gt_i | input | 1 | Lower stage found A greater |
| casc_eq_i | input | 1 | Lower stage found A equal |
| casc_lt_i | input | 1 | Lower stage found A less |
| gt_o | output | 1 | A greater than B |
| eq_o | output | 1 | A equal to B |
| lt_o | output | 1 | A less than B |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the flags. The bench applies each input set on a falling clock edge. It samples the flags two time units later, once the combinational paths have settled and well before the next rising edge. The single stage is swept over all operand pairs under all eight cascade patterns. The two-stage chain is swept over all 8-bit pairs against an integer reference.

// File: rtl/magcmp_pkg.sv
// Package: shared types for the magnitude comparator stage.
// Assumes: a relation is carried as three flags, legal when one-hot.
package magcmp_pkg;

    // Result of a compare: greater, equal, less.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    // Verdict an isolated (least significant) stage must receive.
    localparam rel_t REL_NEUTRAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/magcmp_bitcell.sv
// Module: per-bit relation cells for two operands.
// Assumes: nothing; one greater/equal pair per bit position.
module magcmp_bitcell #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] bit_gt,
    output logic [W-1:0] bit_eq
);

    for (genvar i = 0; i < W; i++) begin : g_cell
        // Bit i of A wins when it is 1 and B's bit is 0.
        assign bit_gt[i] = a[i] & ~b[i];
        // Bit i matches when both bits agree.
        assign bit_eq[i] = ~(a[i] ^ b[i]);
    end

endmodule

// File: rtl/magcmp_prio.sv
// Module: MSB-first priority scan over per-bit relations.
// Assumes: bit_gt and bit_eq come from magcmp_bitcell (never both high).
// The first differing bit from the top decides the local verdict.
module magcmp_prio #(
    parameter int W = 4
) (
    input  logic [W-1:0] bit_gt,
    input  logic [W-1:0] bit_eq,
    output logic         loc_gt,
    output logic         loc_eq,
    output logic         loc_lt
);

    logic [W:0]   eq_above;
    logic [W-1:0] gt_hit;
    logic [W-1:0] lt_hit;

    assign eq_above[W] = 1'b1;

    for (genvar i = W - 1; i >= 0; i--) begin : g_scan
        // Prefix of equal bits from the MSB down to bit i.
        assign eq_above[i] = eq_above[i+1] & bit_eq[i];
        // Bit i decides "greater" when every higher bit matched.
        assign gt_hit[i]   = eq_above[i+1] & bit_gt[i];
        // Bit i decides "less" when every higher bit matched.
        assign lt_hit[i]   = eq_above[i+1] & ~bit_eq[i] & ~bit_gt[i];
    end

    // Collapse the per-bit decisions into the local verdict.
    assign loc_gt = |gt_hit;
    assign loc_lt = |lt_hit;
    assign loc_eq = eq_above[0];

endmodule

// File: rtl/magcmp_merge.sv
// Module: merges the local verdict with the lower-stage verdict.
// Assumes: the local verdict is one-hot.
// Equal operands pass the cascade through unchanged.
module magcmp_merge
    import magcmp_pkg::*;
(
    input  rel_t loc,
    input  rel_t casc,
    output rel_t res
);

    // Local verdict wins unless the local operands are equal.
    always_comb begin
        if (loc.eq) res = casc;
        else        res = '{gt: loc.gt, eq: 1'b0, lt: loc.lt};
    end

endmodule

// File: rtl/magcmp_stage.sv
// Module: cascadable unsigned magnitude comparator stage (top).
// Assumes: the LS stage of a chain receives casc = {0,1,0}; combinational.
module magcmp_stage
    import magcmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         casc_gt_i,
    input  logic         casc_eq_i,
    input  logic         casc_lt_i,
    output logic         gt_o,
    output logic         eq_o,
    output logic         lt_o
);

    logic [W-1:0] bit_gt;
    logic [W-1:0] bit_eq;
    rel_t         loc;
    rel_t         casc;
    rel_t         res;

    magcmp_bitcell #(.W(W)) u_cell (
        .a      (a_i),
        .b      (b_i),
        .bit_gt (bit_gt),
        .bit_eq (bit_eq)
    );

    magcmp_prio #(.W(W)) u_prio (
        .bit_gt (bit_gt),
        .bit_eq (bit_eq),
        .loc_gt (loc.gt),
        .loc_eq (loc.eq),
        .loc_lt (loc.lt)
    );

    // Pack the cascade pins into a relation.
    assign casc = '{gt: casc_gt_i, eq: casc_eq_i, lt: casc_lt_i};

    magcmp_merge u_merge (
        .loc  (loc),
        .casc (casc),
        .res  (res)
    );

    // Drive the result pins.
    assign gt_o = res.gt;
    assign eq_o = res.eq;
    assign lt_o = res.lt;

endmodule

// File: rtl/magcmp_stage_chk.sv
// Module: assertion checker for magcmp_stage, bound to every instance.
// Assumes: combinational block; immediate checks on settled values.
module magcmp_stage_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         casc_gt_i,
    input logic         casc_eq_i,
    input logic         casc_lt_i,
    input logic         gt_o,
    input logic         eq_o,
    input logic         lt_o
);

    // Relates the result pins to the operand order and cascade pins.
    always_comb begin
        if (a_i > b_i) begin
            p_greater_r1: assert ({gt_o, eq_o, lt_o} == 3'b100)
                else $error("R1 greater flags wrong");
        end
        if (a_i < b_i) begin
            p_less_r2: assert ({gt_o, eq_o, lt_o} == 3'b001)
                else $error("R2 less flags wrong");
        end
        if (a_i == b_i) begin
            p_pass_r3: assert ({gt_o, eq_o, lt_o} == {casc_gt_i, casc_eq_i, casc_lt_i})
                else $error("R3 cascade not forwarded");
        end
        if ($countones({casc_gt_i, casc_eq_i, casc_lt_i}) == 1) begin
            p_onehot_r4: assert ($countones({gt_o, eq_o, lt_o}) == 1)
                else $error("R4 result not one-hot");
        end
    end

endmodule

bind magcmp_stage magcmp_stage_chk #(.W(W)) u_chk (.*);

// File: tb/magcmp_stage_tb.sv
// Bench: directed sweeps of a single stage and of a two-stage chain.
module magcmp_stage_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] a, b;
    logic       cg, ce, cl;
    logic       gt, eq, lt;
    logic [7:0] wa, wb;
    logic       lo_gt, lo_eq, lo_lt;
    logic       hi_gt, hi_eq, hi_lt;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    magcmp_stage dut_i (
        .a_i(a), .b_i(b), .casc_gt_i(cg), .casc_eq_i(ce), .casc_lt_i(cl),
        .gt_o(gt), .eq_o(eq), .lt_o(lt)
    );

    magcmp_stage chain_lo_i (
        .a_i(wa[3:0]), .b_i(wb[3:0]),
        .casc_gt_i(1'b0), .casc_eq_i(1'b1), .casc_lt_i(1'b0),
        .gt_o(lo_gt), .eq_o(lo_eq), .lt_o(lo_lt)
    );

    magcmp_stage chain_hi_i (
        .a_i(wa[7:4]), .b_i(wb[7:4]),
        .casc_gt_i(lo_gt), .casc_eq_i(lo_eq), .casc_lt_i(lo_lt),
        .gt_o(hi_gt), .eq_o(hi_eq), .lt_o(hi_lt)
    );

    task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: a=%0d b=%0d actual=%b expected=%b", req, a, b, act, exp);
        end
    endtask

    task automatic apply(input int av, input int bv, input logic [2:0] c);
        @(negedge clk);
        a = av[3:0]; b = bv[3:0]; {cg, ce, cl} = c;
        #2;
    endtask

    // Idle state: equal operands with neutral cascade give equal (R3).
    task automatic t_idle();
        apply(0, 0, 3'b010);
        check3("R3", {gt, eq, lt}, 3'b010);
    endtask

    // Named corner cases at the MSB boundary (R5).
    task automatic t_corners();
        apply(8, 7, 3'b010);   check3("R5", {gt, eq, lt}, 3'b100);
        apply(1, 14, 3'b010);  check3("R5", {gt, eq, lt}, 3'b001);
        apply(15, 0, 3'b001);  check3("R5", {gt, eq, lt}, 3'b100);
        apply(0, 15, 3'b100);  check3("R5", {gt, eq, lt}, 3'b001);
    endtask

    // Full single-stage sweep: R1, R2, R3, R4, R6.
    task automatic t_sweep();
        for (int c = 0; c < 8; c++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    apply(x, y, c[2:0]);
                    if (x > y)       check3("R1/R6", {gt, eq, lt}, 3'b100);
                    else if (x < y)  check3("R2/R6", {gt, eq, lt}, 3'b001);
                    else             check3("R3", {gt, eq, lt}, c[2:0]);
                    if (c == 1 || c == 2 || c == 4) begin
                        checks++;
                        if ($countones({gt, eq, lt}) != 1) begin
                            errors++;
                            $display("FAIL R4: actual=%b expected one-hot", {gt, eq, lt});
                        end
                    end
                end
            end
        end
    endtask

    // Two-stage 8-bit chain against integer compare (R7).
    task automatic t_chain();
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                @(negedge clk);
                wa = x[7:0]; wb = y[7:0];
                #2;
                checks++;
                if ({hi_gt, hi_eq, hi_lt} !== {x > y, x == y, x < y}) begin
                    errors++;
                    $display("FAIL R7: a=%0d b=%0d actual=%b expected=%b",
                             x, y, {hi_gt, hi_eq, hi_lt}, {x > y, x == y, x < y});
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        a = '0; b = '0; {cg, ce, cl} = 3'b010; wa = '0; wb = '0;
        t_idle();
        t_corners();
        t_sweep();
        t_chain();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule